// File: doc/BRIEF.md
# Variable-Page-Size Three-Level Table Walker

This block turns a 40-bit device virtual address into a 40-bit physical address. It walks a three-level translation structure held in memory: a catalogue, then a directory, then a page table. A single request carries the virtual address and a write flag. The walker issues one memory read per level on a simple request/response port and takes a response after any delay. It ends with either a physical address plus page attributes, or a fault code that names where the walk stopped.

The directory entry carries a 3-bit page-size code, and the final level of the same walk depends on it. The code picks a data page of 4 KB, 16 KB, 64 KB, 256 KB, 1 MB or 2 MB. It sets how far the page-table base is aligned, how many virtual bits index the page table, how many low bits pass through as page offset, and where the physical page number sits in the last entry. Only one translation is in flight at a time.

The controller is a state machine with eight states. IDLE waits for a request. CAT_REQ, DIR_REQ and TBL_REQ each issue one read. CAT_WAIT, DIR_WAIT and TBL_WAIT each hold until the read data arrives. DONE presents the result for one cycle.

The transitions are:
- IDLE→CAT_REQ when a request is accepted.
- Each *_REQ state moves to its *_WAIT state after one cycle.
- CAT_WAIT→DIR_REQ and DIR_WAIT→TBL_REQ on a clean entry.
- CAT_WAIT→DONE and DIR_WAIT→DONE on a fault.
- TBL_WAIT→DONE on any response.
- DONE→IDLE always.

Top module: `ptw_walker`

## Requirements
- R1: After reset, req_ready is 1 while rsp_valid and mem_req_valid are 0.
- R2: A request is taken on a cycle with req_valid and req_ready both high. req_ready then stays low up to and including the single cycle in which rsp_valid is high. In the next cycle req_ready is 1 again and rsp_valid is 0.
- R3: The first read of a walk is narrow (mem_req_wide = 0) at address {root_base, vaddr[39:30], 2'b00}.
- R4: Catalogue entry layout: bit 0 is valid, bit 1 is pending, and bits 31:4 give physical bits 39:12 of the directory. The directory read is wide, at that base plus vaddr[29:21] times 8.
- R5: Directory entry layout: bit 0 is valid, bits 3:1 are the size code, bits 39:4 are the table base and bit 40 is pending. Codes 0 to 5 select pages of 2^12, 2^14, 2^16, 2^18, 2^20 and 2^21 bytes.
- R6: The table read is wide. Its address is {pde[39:4], 4'b0000} with the bits below the table alignment cleared, plus vaddr[20:log2 page] times 8. The log2 alignment is 12, 10, 8, 6, 4 and 4 for codes 0 to 5.
- R7: On success, rsp_fault is 0 and rsp_paddr is {pte[39:log2 page], vaddr[log2 page-1:0]}. A successful walk makes exactly three reads.
- R8: Page-table entry flags are valid (bit 0), read-only (bit 1), coherent (bit 2), cache bypass (bit 3), pending (bit 4) and protect (bit 5). rsp_attr is {protect, bypass, coherent, read-only}.
- R9: An entry with valid clear or pending set ends the walk with no further read. rsp_fault is then 1 for the catalogue, 2 for the directory or 3 for the page table.
- R10: A directory size code of 6 or 7 ends the walk after two reads, with rsp_fault = 4.
- R11: A write request that reaches a read-only table entry gets rsp_fault = 5. A read request to the same entry succeeds.
- R12: Whenever rsp_fault is nonzero, rsp_paddr and rsp_attr are 0.
- R13: Each read is a one-cycle mem_req_valid pulse. The walker waits for mem_rsp_valid whatever the memory latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| root_base | input | 28 | Physical bits 39:12 of the catalogue |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_vaddr | input | 40 | Virtual address to translate |
| req_write | input | 1 | Request is a write access |
| mem_req_valid | output | 1 | Read request pulse |
| mem_req_addr | output | 40 | Byte address of the entry read |
| mem_req_wide | output | 1 | 1 for a 64-bit read, 0 for a low 32-bit word |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data (low word used for narrow reads) |
| rsp_valid | output | 1 | Result valid for one cycle |
| rsp_paddr | output | 40 | Translated physical address |
| rsp_attr | output | 4 | Page attributes {protect, bypass, coherent, read-only} |
| rsp_fault | output | 3 | 0 none, 1 catalogue, 2 directory, 3 table, 4 bad size, 5 permission |

## Verification
The bench builds the walker at the package's default widths, a 40-bit virtual and physical space. At those widths every one of the six page sizes and both illegal size codes can be placed in a real table in the bench's sparse memory model. The bench runs the model with response latencies of zero, one and four cycles, so the wait states are held for different lengths. A directory base with junk below the 4 KB alignment shows whether the alignment mask is applied. A 2 MB walk with all offset bits set shows that the full 21-bit offset passes through.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int VA_W       = 40;
    localparam int PA_W       = 40;
    localparam int WORD_W     = 64;
    localparam int NARROW_W   = 32;
    localparam int PG4K_LOG2  = 12;
    localparam int ROOT_W     = PA_W - PG4K_LOG2;
    localparam int CAT_HI     = 39;
    localparam int CAT_LO     = 30;
    localparam int DIR_HI     = 29;
    localparam int DIR_LO     = 21;
    localparam int PT_TOP     = DIR_LO;
    localparam int CAT_ESZ    = 2;
    localparam int WIDE_ESZ   = 3;
    localparam int MIN_ALIGN  = 4;
    localparam int LOG2_W     = 5;
    localparam int CODE_W     = 3;
    localparam int ATTR_W     = 4;
    localparam int FAULT_W    = 3;
    localparam int NUM_SIZES  = 6;

    // catalogue entry fields
    localparam int CE_VALID   = 0;
    localparam int CE_PEND    = 1;
    localparam int CE_BASE_LO = 4;
    localparam int CE_BASE_HI = 31;
    // directory entry fields
    localparam int DE_VALID   = 0;
    localparam int DE_CODE_LO = 1;
    localparam int DE_CODE_HI = 3;
    localparam int DE_BASE_LO = 4;
    localparam int DE_BASE_HI = 39;
    localparam int DE_PEND    = 40;
    // page-table entry fields
    localparam int TE_VALID   = 0;
    localparam int TE_RO      = 1;
    localparam int TE_CC      = 2;
    localparam int TE_BYP     = 3;
    localparam int TE_PEND    = 4;
    localparam int TE_PROT    = 5;

    typedef enum logic [FAULT_W-1:0] {
        FLT_NONE = 3'd0,
        FLT_CAT  = 3'd1,
        FLT_DIR  = 3'd2,
        FLT_TBL  = 3'd3,
        FLT_SIZE = 3'd4,
        FLT_PERM = 3'd5
    } fault_e;

    typedef enum logic [1:0] {
        LVL_CAT = 2'd0,
        LVL_DIR = 2'd1,
        LVL_TBL = 2'd2
    } level_e;

    typedef enum logic [2:0] {
        S_IDLE     = 3'd0,
        S_CAT_REQ  = 3'd1,
        S_CAT_WAIT = 3'd2,
        S_DIR_REQ  = 3'd3,
        S_DIR_WAIT = 3'd4,
        S_TBL_REQ  = 3'd5,
        S_TBL_WAIT = 3'd6,
        S_DONE     = 3'd7
    } state_e;

    // size code to log2 of page bytes; illegal codes give 0
    function automatic logic [LOG2_W-1:0] code_to_log2(input logic [CODE_W-1:0] code);
        logic [LOG2_W-1:0] r;
        if (code < CODE_W'(NUM_SIZES - 1))
            r = LOG2_W'(PG4K_LOG2 + 2 * int'(code));
        else if (code == CODE_W'(NUM_SIZES - 1))
            r = LOG2_W'(PT_TOP);
        else
            r = '0;
        return r;
    endfunction
endpackage

// File: rtl/ptw_size_decode.sv
module ptw_size_decode
    import ptw_pkg::*;
#(
    parameter int ADDR_W = PA_W
) (
    input  logic [CODE_W-1:0] code_i,
    output logic              legal_o,
    output logic [LOG2_W-1:0] log2_o,
    output logic [ADDR_W-1:0] page_mask_o,
    output logic [ADDR_W-1:0] tbl_mask_o
);
    int align;

    always_comb begin
        log2_o  = code_to_log2(code_i);
        legal_o = (code_i < CODE_W'(NUM_SIZES));
        align   = PT_TOP + WIDE_ESZ - int'(log2_o);
        if (align < MIN_ALIGN)
            align = MIN_ALIGN;
    end

    for (genvar i = 0; i < ADDR_W; i++) begin : g_mask
        assign page_mask_o[i] = (i < int'(log2_o));
        assign tbl_mask_o[i]  = (i < align);
    end
endmodule

// File: rtl/ptw_entry_eval.sv
module ptw_entry_eval
    import ptw_pkg::*;
(
    input  level_e            level_i,
    input  logic [WORD_W-1:0] data_i,
    input  logic              is_write_i,
    input  logic              size_legal_i,
    output fault_e            fault_o,
    output logic [ATTR_W-1:0] attr_o
);
    logic unused_bits;
    assign unused_bits = ^{data_i[WORD_W-1:DE_PEND+1], data_i[DE_PEND-1:TE_PROT+1]};

    always_comb begin
        fault_o = FLT_NONE;
        unique case (level_i)
            LVL_CAT: begin
                if (!data_i[CE_VALID] || data_i[CE_PEND])
                    fault_o = FLT_CAT;
            end
            LVL_DIR: begin
                if (!data_i[DE_VALID] || data_i[DE_PEND])
                    fault_o = FLT_DIR;
                else if (!size_legal_i)
                    fault_o = FLT_SIZE;
            end
            LVL_TBL: begin
                if (!data_i[TE_VALID] || data_i[TE_PEND])
                    fault_o = FLT_TBL;
                else if (is_write_i && data_i[TE_RO])
                    fault_o = FLT_PERM;
            end
            default: fault_o = FLT_NONE;
        endcase
        attr_o = {data_i[TE_PROT], data_i[TE_BYP], data_i[TE_CC], data_i[TE_RO]};
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ROOT_W-1:0]   root_base,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [VA_W-1:0]     req_vaddr,
    input  logic                req_write,
    output logic                mem_req_valid,
    output logic [PA_W-1:0]     mem_req_addr,
    output logic                mem_req_wide,
    input  logic                mem_rsp_valid,
    input  logic [WORD_W-1:0]   mem_rsp_data,
    output logic                rsp_valid,
    output logic [PA_W-1:0]     rsp_paddr,
    output logic [ATTR_W-1:0]   rsp_attr,
    output logic [FAULT_W-1:0]  rsp_fault
);
    state_e              state, state_nx;
    logic [VA_W-1:0]     vaddr_q;
    logic                write_q;
    logic [ROOT_W-1:0]   dir_base_q;
    logic [PA_W-1:0]     tbl_base_q;
    logic [CODE_W-1:0]   code_q;
    logic [PA_W-1:0]     paddr_q;
    logic [ATTR_W-1:0]   attr_q;
    fault_e              fault_q;

    logic [CODE_W-1:0]   size_code;
    logic                size_legal;
    logic [LOG2_W-1:0]   size_log2;
    logic [PA_W-1:0]     page_mask;
    logic [PA_W-1:0]     tbl_mask;
    logic [PA_W-1:0]     pt_off;
    level_e              level;
    fault_e              ent_fault;
    logic [ATTR_W-1:0]   ent_attr;

    // size code comes from the live response while the directory entry returns
    assign size_code = (state == S_DIR_WAIT) ? mem_rsp_data[DE_CODE_HI:DE_CODE_LO] : code_q;

    ptw_size_decode #(.ADDR_W(PA_W)) u_size (
        .code_i      (size_code),
        .legal_o     (size_legal),
        .log2_o      (size_log2),
        .page_mask_o (page_mask),
        .tbl_mask_o  (tbl_mask)
    );

    always_comb begin
        unique case (state)
            S_CAT_WAIT: level = LVL_CAT;
            S_DIR_WAIT: level = LVL_DIR;
            default:    level = LVL_TBL;
        endcase
    end

    ptw_entry_eval u_eval (
        .level_i      (level),
        .data_i       (mem_rsp_data),
        .is_write_i   (write_q),
        .size_legal_i (size_legal),
        .fault_o      (ent_fault),
        .attr_o       (ent_attr)
    );

    assign pt_off = PA_W'({vaddr_q[PT_TOP-1:0] >> size_log2, {WIDE_ESZ{1'b0}}});

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= S_IDLE;
        else
            state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:     if (req_valid) state_nx = S_CAT_REQ;
            S_CAT_REQ:  state_nx = S_CAT_WAIT;
            S_CAT_WAIT: if (mem_rsp_valid)
                            state_nx = (ent_fault != FLT_NONE) ? S_DONE : S_DIR_REQ;
            S_DIR_REQ:  state_nx = S_DIR_WAIT;
            S_DIR_WAIT: if (mem_rsp_valid)
                            state_nx = (ent_fault != FLT_NONE) ? S_DONE : S_TBL_REQ;
            S_TBL_REQ:  state_nx = S_TBL_WAIT;
            S_TBL_WAIT: if (mem_rsp_valid) state_nx = S_DONE;
            S_DONE:     state_nx = S_IDLE;
        endcase
    end

    // walk datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vaddr_q    <= '0;
            write_q    <= 1'b0;
            dir_base_q <= '0;
            tbl_base_q <= '0;
            code_q     <= '0;
            paddr_q    <= '0;
            attr_q     <= '0;
            fault_q    <= FLT_NONE;
        end else begin
            unique case (state)
                S_IDLE: if (req_valid) begin
                    vaddr_q <= req_vaddr;
                    write_q <= req_write;
                    paddr_q <= '0;
                    attr_q  <= '0;
                    fault_q <= FLT_NONE;
                end
                S_CAT_WAIT: if (mem_rsp_valid) begin
                    if (ent_fault != FLT_NONE)
                        fault_q <= ent_fault;
                    else
                        dir_base_q <= mem_rsp_data[CE_BASE_HI:CE_BASE_LO];
                end
                S_DIR_WAIT: if (mem_rsp_valid) begin
                    if (ent_fault != FLT_NONE) begin
                        fault_q <= ent_fault;
                    end else begin
                        code_q     <= mem_rsp_data[DE_CODE_HI:DE_CODE_LO];
                        tbl_base_q <= {mem_rsp_data[DE_BASE_HI:DE_BASE_LO], {DE_BASE_LO{1'b0}}};
                    end
                end
                S_TBL_WAIT: if (mem_rsp_valid) begin
                    if (ent_fault != FLT_NONE) begin
                        fault_q <= ent_fault;
                    end else begin
                        paddr_q <= (mem_rsp_data[PA_W-1:0] & ~page_mask) | (vaddr_q[PA_W-1:0] & page_mask);
                        attr_q  <= ent_attr;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready     = (state == S_IDLE);
        rsp_valid     = (state == S_DONE);
        rsp_paddr     = paddr_q;
        rsp_attr      = attr_q;
        rsp_fault     = fault_q;
        mem_req_valid = 1'b0;
        mem_req_wide  = 1'b0;
        mem_req_addr  = '0;
        unique case (state)
            S_CAT_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = {root_base, vaddr_q[CAT_HI:CAT_LO], {CAT_ESZ{1'b0}}};
            end
            S_DIR_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_wide  = 1'b1;
                mem_req_addr  = {dir_base_q, vaddr_q[DIR_HI:DIR_LO], {WIDE_ESZ{1'b0}}};
            end
            S_TBL_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_wide  = 1'b1;
                mem_req_addr  = (tbl_base_q & ~tbl_mask) | pt_off;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk
    import ptw_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [ROOT_W-1:0]  root_base,
    input logic               req_valid,
    input logic               req_ready,
    input logic [VA_W-1:0]    req_vaddr,
    input logic               req_write,
    input logic               mem_req_valid,
    input logic [PA_W-1:0]    mem_req_addr,
    input logic               mem_req_wide,
    input logic               rsp_valid,
    input logic [PA_W-1:0]    rsp_paddr,
    input logic [ATTR_W-1:0]  rsp_attr,
    input logic [FAULT_W-1:0] rsp_fault
);
    logic [1:0]      n_rd;
    logic [VA_W-1:0] va_l;
    logic            wr_l;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            n_rd <= '0;
            va_l <= '0;
            wr_l <= 1'b0;
        end else if (req_valid && req_ready) begin
            n_rd <= '0;
            va_l <= req_vaddr;
            wr_l <= req_write;
        end else if (mem_req_valid && n_rd != 2'd3) begin
            n_rd <= n_rd + 2'd1;
        end
    end

    assert_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);
    assert_ready_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);
    assert_back_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (req_ready && !rsp_valid));
    assert_cat_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && n_rd == 2'd0 |->
            (!mem_req_wide && mem_req_addr == {root_base, va_l[CAT_HI:CAT_LO], 2'b00}));
    assert_wide_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && n_rd != 2'd0 |-> mem_req_wide);
    assert_three_reads_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault == 3'd0 |-> n_rd == 2'd3);
    assert_read_limit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> n_rd != 2'd3);
    assert_cat_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault == 3'd1 |-> n_rd == 2'd1);
    assert_size_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault == 3'd4 |-> n_rd == 2'd2);
    assert_perm_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault == 3'd5 |-> wr_l);
    assert_fault_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault != 3'd0 |-> (rsp_paddr == '0 && rsp_attr == '0));
    assert_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);
endmodule

bind ptw_walker ptw_walker_chk u_chk (.*);

// File: tb/ptw_walker_test.sv
module ptw_walker_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [27:0] root_base;
    logic        req_valid, req_ready, req_write;
    logic [39:0] req_vaddr;
    logic        mem_req_valid, mem_req_wide;
    logic [39:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [63:0] mem_rsp_data;
    logic        rsp_valid;
    logic [39:0] rsp_paddr;
    logic [3:0]  rsp_attr;
    logic [2:0]  rsp_fault;

    always #5 clk = ~clk;

    ptw_walker uut (
        .clk(clk), .rst_n(rst_n), .root_base(root_base),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_write(req_write),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr), .mem_req_wide(mem_req_wide),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_attr(rsp_attr), .rsp_fault(rsp_fault)
    );

    localparam logic [27:0] ROOT = 28'h0000010;

    typedef struct {
        logic [39:0] pa;
        logic [3:0]  attr;
        logic [2:0]  flt;
        int          reads;
        logic [39:0] cat_addr;
        string       tag;
    } exp_t;

    exp_t sb[$];
    int tests = 0;
    int fails = 0;
    int mem_lat = 0;
    bit finished = 0;
    logic [63:0] mem_arr [logic [39:0]];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // memory model: response lat+1 negedges after the request is seen
    int          m_cnt = 0;
    logic [39:0] m_addr;
    logic        m_wide;
    always @(negedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (m_cnt > 0) begin
            m_cnt--;
            if (m_cnt == 0) begin
                logic [63:0] d;
                d = mem_arr.exists(m_addr) ? mem_arr[m_addr] : 64'h0;
                mem_rsp_data  <= m_wide ? d : {32'h0, d[31:0]};
                mem_rsp_valid <= 1'b1;
            end
        end
        if (rst_n && mem_req_valid) begin
            m_addr = mem_req_addr;
            m_wide = mem_req_wide;
            m_cnt  = mem_lat + 1;
        end
    end

    // monitor / scoreboard
    int          rd_cnt = 0;
    logic [39:0] first_addr;
    logic        first_wide;
    bit          post_rsp = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (post_rsp) begin
                check(req_ready === 1'b1 && rsp_valid === 1'b0, "R2", "idle after response",
                      {62'h0, req_ready, rsp_valid}, 64'h2);
                post_rsp = 0;
            end
            if (mem_req_valid) begin
                if (rd_cnt == 0) begin
                    first_addr = mem_req_addr;
                    first_wide = mem_req_wide;
                end
                rd_cnt++;
            end
            if (rsp_valid) begin
                if (sb.size() == 0) begin
                    check(0, "R2", "unexpected response", 64'h1, 64'h0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(rsp_fault === e.flt, e.tag, "fault", 64'(rsp_fault), 64'(e.flt));
                    check(rsp_paddr === e.pa, e.tag, "paddr", 64'(rsp_paddr), 64'(e.pa));
                    check(rsp_attr === e.attr, e.tag, "attr", 64'(rsp_attr), 64'(e.attr));
                    check(rd_cnt == e.reads, e.tag, "read count", 64'(rd_cnt), 64'(e.reads));
                    check(first_addr === e.cat_addr && first_wide === 1'b0, "R3",
                          "catalogue read", 64'({first_wide, first_addr}), 64'(e.cat_addr));
                    check(req_ready === 1'b0, "R2", "ready low at response", 64'(req_ready), 64'h0);
                end
                rd_cnt = 0;
                post_rsp = 1;
            end
        end
    end

    function automatic int size_log2(input logic [2:0] code);
        case (code)
            3'd0: return 12;
            3'd1: return 14;
            3'd2: return 16;
            3'd3: return 18;
            3'd4: return 20;
            3'd5: return 21;
            default: return 12;
        endcase
    endfunction

    function automatic logic [39:0] va_of(input int k, input logic [20:0] low);
        return {10'(k + 1), 9'h0A5, low};
    endfunction

    // builds catalogue, directory and table entries for mapping k
    task automatic map_page(input int k, input logic [39:0] va, input logic [2:0] code,
                            input logic [63:0] pce_x, input logic [63:0] pde_x,
                            input logic [63:0] pte_flags, output logic [39:0] page_base);
        logic [39:0] dirb, tblb;
        int L;
        dirb      = 40'h01_0000_0000 + 40'(k) * 40'h00_0010_0000;
        tblb      = dirb + 40'h00_0008_0000;
        page_base = 40'h40_0000_0000 + 40'(k) * 40'h00_0100_0000;
        L         = size_log2(code);
        mem_arr[{ROOT, va[39:30], 2'b00}] = ({32'h0, dirb[39:12], 4'h0} | 64'h1) ^ pce_x;
        mem_arr[dirb + {28'h0, va[29:21], 3'b000}] = ({24'h0, tblb} | {60'h0, code, 1'b1}) ^ pde_x;
        mem_arr[tblb + 40'((va[20:0] >> L) << 3)] = {24'h0, page_base} | pte_flags;
    endtask

    task automatic run_walk(input logic [39:0] va, input logic wr, input logic [39:0] pa,
                            input logic [3:0] attr, input logic [2:0] flt, input int reads,
                            input string tag);
        exp_t e;
        e.pa = pa; e.attr = attr; e.flt = flt; e.reads = reads;
        e.cat_addr = {ROOT, va[39:30], 2'b00}; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_write = wr;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    function automatic logic [39:0] exp_pa(input logic [39:0] pb, input logic [39:0] va,
                                           input logic [2:0] code);
        logic [39:0] m;
        m = (40'h1 << size_log2(code)) - 40'h1;
        return pb | (va & m);
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [39:0] pb, va;
        rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_write = 1'b0;
        root_base = ROOT; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready === 1'b1 && rsp_valid === 1'b0 && mem_req_valid === 1'b0, "R1",
              "reset outputs", {61'h0, req_ready, rsp_valid, mem_req_valid}, 64'h4);

        // R4 R5 R6 R7: 4 KB, junk below table alignment in the directory base
        va = va_of(0, 21'h1ABCDE);
        map_page(0, va, 3'd0, 64'h0, 64'hFF0, 64'h01, pb);
        run_walk(va, 1'b0, exp_pa(pb, va, 3'd0), 4'h0, 3'd0, 3, "R4 R5 R6 R7 4KB");

        mem_lat = 1;
        va = va_of(1, 21'h1ABCDE);
        map_page(1, va, 3'd1, 64'h0, 64'h0, 64'h01, pb);
        run_walk(va, 1'b0, exp_pa(pb, va, 3'd1), 4'h0, 3'd0, 3, "R5 R6 R7 16KB");

        mem_lat = 0;
        va = va_of(2, 21'h0F1234);
        map_page(2, va, 3'd2, 64'h0, 64'h0, 64'h05, pb);
        run_walk(va, 1'b0, exp_pa(pb, va, 3'd2), 4'h2, 3'd0, 3, "R5 R6 R8 64KB coherent");

        va = va_of(3, 21'h0ABCDE);
        map_page(3, va, 3'd3, 64'h0, 64'h0, 64'h09, pb);
        run_walk(va, 1'b0, exp_pa(pb, va, 3'd3), 4'h4, 3'd0, 3, "R5 R6 R8 256KB bypass");

        va = va_of(4, 21'h1FFFFF);
        map_page(4, va, 3'd4, 64'h0, 64'h0, 64'h21, pb);
        run_walk(va, 1'b0, exp_pa(pb, va, 3'd4), 4'h8, 3'd0, 3, "R5 R6 R8 1MB protect");

        // R11: read-only entry readable, write faults
        va = va_of(5, 21'h1FFFFF);
        map_page(5, va, 3'd5, 64'h0, 64'h0, 64'h2F, pb);
        run_walk(va, 1'b0, exp_pa(pb, va, 3'd5), 4'hF, 3'd0, 3, "R7 R8 R11 2MB read");
        run_walk(va, 1'b1, 40'h0, 4'h0, 3'd5, 3, "R11 R12 write read-only");

        va = va_of(6, 21'h012345);
        map_page(6, va, 3'd0, 64'h0, 64'h0, 64'h01, pb);
        run_walk(va, 1'b1, exp_pa(pb, va, 3'd0), 4'h0, 3'd0, 3, "R11 write writable");

        // R9: faults at each level
        run_walk({10'h3FF, 30'h0ABCDEF}, 1'b0, 40'h0, 4'h0, 3'd1, 1, "R9 R12 catalogue invalid");
        va = va_of(7, 21'h0);
        map_page(7, va, 3'd0, 64'h2, 64'h0, 64'h01, pb);
        run_walk(va, 1'b0, 40'h0, 4'h0, 3'd1, 1, "R9 catalogue pending");
        va = va_of(8, 21'h0);
        map_page(8, va, 3'd0, 64'h0, 64'h1, 64'h01, pb);
        run_walk(va, 1'b0, 40'h0, 4'h0, 3'd2, 2, "R9 directory invalid");
        va = va_of(9, 21'h0);
        map_page(9, va, 3'd0, 64'h0, 64'h1 << 40, 64'h01, pb);
        run_walk(va, 1'b0, 40'h0, 4'h0, 3'd2, 2, "R9 directory pending");

        // R10: illegal size codes
        va = va_of(10, 21'h0);
        map_page(10, va, 3'd6, 64'h0, 64'h0, 64'h01, pb);
        run_walk(va, 1'b0, 40'h0, 4'h0, 3'd4, 2, "R10 code 6");
        va = va_of(11, 21'h0);
        map_page(11, va, 3'd7, 64'h0, 64'h0, 64'h01, pb);
        run_walk(va, 1'b0, 40'h0, 4'h0, 3'd4, 2, "R10 R12 code 7");

        va = va_of(12, 21'h001000);
        map_page(12, va, 3'd0, 64'h0, 64'h0, 64'h00, pb);
        run_walk(va, 1'b0, 40'h0, 4'h0, 3'd3, 3, "R9 table invalid");
        va = va_of(13, 21'h001000);
        map_page(13, va, 3'd0, 64'h0, 64'h0, 64'h11, pb);
        run_walk(va, 1'b0, 40'h0, 4'h0, 3'd3, 3, "R9 R12 table pending");

        // R13: slow memory
        mem_lat = 4;
        va = va_of(14, 21'h13579B);
        map_page(14, va, 3'd2, 64'h0, 64'h0, 64'h01, pb);
        run_walk(va, 1'b0, exp_pa(pb, va, 3'd2), 4'h0, 3'd0, 3, "R13 latency 4");

        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R2", "responses outstanding", 64'(sb.size()), 64'h0);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule